// File: doc/BRIEF.md
# Mode-Selected Parallel Port Byte FIFO

This block is the host-visible register front of an enhanced parallel port. It holds one byte FIFO. A mode field in an extended control register chooses which host ports are live and where the FIFO drains to. In the forward modes, host writes fill the FIFO and a downstream transmit handshake engine empties it. Every entry carries a tag that marks it as a data byte or a command byte, set by the port address the host wrote through. In the reverse direction, a receive engine fills the FIFO and the host reads the bytes out. A test mode lets software push bytes into the FIFO and pull them back through the FIFO port, which is also how a stalled transfer is drained. A configuration mode turns the FIFO port and its neighbour into two read-only capability registers.

The host side is a simple strobe bus with a 3-bit offset. Offset 0 is the command port. Offset 4 is the shared FIFO port, which also serves as configuration register A. Offset 5 is configuration register B. Offset 6 is the extended control register. Read data is combinational on the offset. A read strobe at offset 4 dequeues one byte in the modes that allow host reads.

Top module: `lpt_mode_fifo`

## Requirements
- R1: After reset, the extended control register (offset 6) reads 0x01: mode 000 with the empty bit set. `ovf_flag`, `tx_valid` and `rx_ready` are all 0.
- R2: A write to offset 6 stores bits 7:2. Bit 7:5 is the mode, bit 4 is the error-interrupt disable, bit 3 is the DMA enable and bit 2 is the service bit. When read, bit 1 shows FIFO full and bit 0 shows FIFO empty, whatever value was written to those two bits.
- R3: In mode 010, each write to offset 4 enqueues a byte with tag 0. The bytes appear on `tx_byte` in write order with `tx_cmd`=0. One byte is removed per cycle in which `tx_valid` and `tx_ready` are both high.
- R4: In mode 011 with `link_reverse`=0, a write to offset 4 enqueues a byte with tag 0 and a write to offset 0 enqueues a byte with tag 1. Both kinds share one queue in write order.
- R5: The FIFO holds DEPTH entries, where DEPTH is at least 8 (default 16). The full bit is set exactly when DEPTH entries are stored. The empty bit clears as soon as one entry is stored.
- R6: A host write to a live FIFO port while the FIFO is full is dropped and sets `ovf_flag`. The flag stays set until a flush, and the queued contents are unchanged.
- R7: In mode 110, writes to offset 4 enqueue bytes. A read of offset 4 returns the head byte and dequeues it. `tx_valid` stays 0.
- R8: In mode 111, offset 4 reads configuration A: bit 7 is the level-interrupt flag, bits 6:4 are the width ID (001 means 8-bit) and bit 2 is the no-pipeline flag. Offset 5 reads configuration B: bits 5:3 are the IRQ select and bits 2:0 are the DMA select. Host writes to offsets 0 and 4 leave the FIFO untouched.
- R9: Any write to offset 6 that selects mode 000 or 001 flushes the FIFO. This forces the empty bit and clears `ovf_flag`.
- R10: In mode 011 with `link_reverse`=1, `rx_ready` is high exactly when the FIFO is not full, and each accepted `rx_byte` is enqueued. Reads of offset 4 return and dequeue the bytes in arrival order, and `tx_valid` stays 0.
- R11: In modes 000, 001 and 100, writes to offsets 0 and 4 do not change the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (dequeues at offset 4 where allowed) |
| reg_addr | input | 3 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational on offset |
| link_reverse | input | 1 | Peripheral-to-host direction is active |
| tx_valid | output | 1 | Head entry offered to transmit engine |
| tx_byte | output | 8 | Head byte |
| tx_cmd | output | 1 | Head tag, 1 for command byte |
| tx_ready | input | 1 | Transmit engine takes the head entry |
| rx_valid | input | 1 | Receive engine offers a byte |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | FIFO accepts the received byte |
| ovf_flag | output | 1 | Sticky dropped-write flag |

## Verification
Some properties are checked by assertions on every cycle. These are the bound on the fill count, the rule that a push into a full queue leaves the count alone, the rule that a flush leaves the queue empty, the blocking of `tx_valid` in test mode and in reverse mode, the tie between `rx_ready` and the full state, and the storing of the mode field on a control write. Only the bench scenarios can show byte order and tag correctness through the queue, the exact configuration register layouts, the fill level where full appears, and the fact that writes in inactive modes leave no trace. The bench does this by sweeping fill lengths and reading the results back through the ports.

// File: rtl/lpt_fifo_pkg.sv
package lpt_fifo_pkg;

    typedef enum logic [2:0] {
        MD_STD   = 3'b000,
        MD_BYTE  = 3'b001,
        MD_SFIFO = 3'b010,
        MD_ECP   = 3'b011,
        MD_EPP   = 3'b100,
        MD_RSVD  = 3'b101,
        MD_TEST  = 3'b110,
        MD_CFG   = 3'b111
    } port_mode_e;

    typedef struct packed {
        logic       cmd;
        logic [7:0] byte_v;
    } fifo_entry_t;

    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_FIFO = 3'd4;
    localparam logic [2:0] OFF_CFGB = 3'd5;
    localparam logic [2:0] OFF_ECTL = 3'd6;

endpackage

// File: rtl/lpt_tag_fifo.sv
module lpt_tag_fifo
    import lpt_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush_i,
    input  logic        push_i,
    input  fifo_entry_t din_i,
    input  logic        pop_i,
    output fifo_entry_t head_o,
    output logic        empty_o,
    output logic        full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_q, st_d;
    fifo_entry_t mem_q [DEPTH];
    logic        do_push, do_pop;

    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && !empty_o && !flush_i;
    assign head_o  = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            if (do_pop)  st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= din_i;
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R6
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !flush_i) |=> full_o);

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);

endmodule

// File: rtl/lpt_cfg_words.sv
module lpt_cfg_words #(
    parameter logic       LEVEL_IRQ = 1'b1,
    parameter logic [2:0] WIDTH_ID  = 3'b001,
    parameter logic       NO_PIPE   = 1'b1,
    parameter logic [2:0] IRQ_SEL   = 3'b001,
    parameter logic [2:0] DMA_SEL   = 3'b011
) (
    output logic [7:0] cfg_a_o,
    output logic [7:0] cfg_b_o
);
    assign cfg_a_o = {LEVEL_IRQ, WIDTH_ID, 1'b0, NO_PIPE, 2'b00};
    assign cfg_b_o = {2'b00, IRQ_SEL, DMA_SEL};
endmodule

// File: rtl/lpt_mode_fifo.sv
module lpt_mode_fifo
    import lpt_fifo_pkg::*;
#(
    parameter int         DEPTH     = 16,
    parameter logic       LEVEL_IRQ = 1'b1,
    parameter logic [2:0] WIDTH_ID  = 3'b001,
    parameter logic       NO_PIPE   = 1'b1,
    parameter logic [2:0] IRQ_SEL   = 3'b001,
    parameter logic [2:0] DMA_SEL   = 3'b011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       link_reverse,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       tx_cmd,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       rx_ready,
    output logic       ovf_flag
);
    typedef struct packed {
        port_mode_e mode;
        logic       err_dis;
        logic       dma_en;
        logic       svc;
        logic       ovf;
    } ctl_state_t;

    ctl_state_t  ctl_q, ctl_d;
    fifo_entry_t push_entry, head;
    logic        f_empty, f_full, f_push, f_pop, f_flush;
    logic [7:0]  cfg_a, cfg_b;
    logic        ecp_fwd, ecp_rev, host_drain, host_fill_fifo, host_fill_cmd;
    logic        host_push_req, ectl_wr;

    lpt_cfg_words #(
        .LEVEL_IRQ(LEVEL_IRQ), .WIDTH_ID(WIDTH_ID), .NO_PIPE(NO_PIPE),
        .IRQ_SEL(IRQ_SEL), .DMA_SEL(DMA_SEL)
    ) u_cfg (
        .cfg_a_o(cfg_a),
        .cfg_b_o(cfg_b)
    );

    lpt_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (f_flush),
        .push_i  (f_push),
        .din_i   (push_entry),
        .pop_i   (f_pop),
        .head_o  (head),
        .empty_o (f_empty),
        .full_o  (f_full)
    );

    always_comb begin
        ecp_fwd    = (ctl_q.mode == MD_ECP) && !link_reverse;
        ecp_rev    = (ctl_q.mode == MD_ECP) && link_reverse;
        host_drain = (ctl_q.mode == MD_TEST) || ecp_rev;
        host_fill_fifo = reg_wr && (reg_addr == OFF_FIFO) &&
            ((ctl_q.mode == MD_SFIFO) || ecp_fwd || (ctl_q.mode == MD_TEST));
        host_fill_cmd  = reg_wr && (reg_addr == OFF_CMD) && ecp_fwd;
        host_push_req  = host_fill_fifo || host_fill_cmd;
        ectl_wr        = reg_wr && (reg_addr == OFF_ECTL);

        rx_ready = ecp_rev && !f_full;
        tx_valid = !f_empty && ((ctl_q.mode == MD_SFIFO) || ecp_fwd);
        tx_byte  = head.byte_v;
        tx_cmd   = head.cmd;

        if (ecp_rev) begin
            push_entry = '{cmd: 1'b0, byte_v: rx_byte};
            f_push     = rx_valid;
        end else begin
            push_entry = '{cmd: host_fill_cmd, byte_v: reg_wdata};
            f_push     = host_push_req;
        end
        f_pop   = (tx_valid && tx_ready) ||
                  (host_drain && reg_rd && (reg_addr == OFF_FIFO));
        f_flush = ectl_wr && (reg_wdata[7:5] == MD_STD || reg_wdata[7:5] == MD_BYTE);

        ctl_d = ctl_q;
        if (ectl_wr) begin
            ctl_d.mode    = port_mode_e'(reg_wdata[7:5]);
            ctl_d.err_dis = reg_wdata[4];
            ctl_d.dma_en  = reg_wdata[3];
            ctl_d.svc     = reg_wdata[2];
        end
        if (f_flush)
            ctl_d.ovf = 1'b0;
        else if (host_push_req && f_full)
            ctl_d.ovf = 1'b1;

        reg_rdata = 8'h00;
        case (reg_addr)
            OFF_ECTL: reg_rdata = {ctl_q.mode, ctl_q.err_dis, ctl_q.dma_en,
                                   ctl_q.svc, f_full, f_empty};
            OFF_FIFO: begin
                if (ctl_q.mode == MD_CFG)        reg_rdata = cfg_a;
                else if (host_drain && !f_empty) reg_rdata = head.byte_v;
            end
            OFF_CFGB: if (ctl_q.mode == MD_CFG) reg_rdata = cfg_b;
            default:  reg_rdata = 8'h00;
        endcase
    end

    assign ovf_flag = ctl_q.ovf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: MD_STD, default: 1'b0};
        else        ctl_q <= ctl_d;
    end

    // R2
    mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_ECTL) |=> (ctl_q.mode == $past(reg_wdata[7:5])));

    // R3
    tx_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !f_empty);

    // R7
    test_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MD_TEST) |-> !tx_valid);

    // R10
    rev_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MD_ECP && link_reverse) |-> !tx_valid);

    // R10
    rx_ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !f_full);

endmodule

// File: tb/lpt_mode_fifo_bench.sv
module lpt_mode_fifo_bench;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       link_reverse = 1'b0;
    logic       tx_valid, tx_cmd, rx_ready, ovf_flag;
    logic [7:0] tx_byte;
    logic       tx_ready = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    lpt_mode_fifo #(.DEPTH(DEPTH)) u_lpt_mode_fifo (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_reverse(link_reverse), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_cmd(tx_cmd), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, input logic pop, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = pop;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tx_take(input string req, input int exp_b, input int exp_c);
        @(negedge clk);
        check(req, int'(tx_valid), 1);
        check(req, int'(tx_byte), exp_b);
        check(req, int'(tx_cmd), exp_c);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + 5) & 8'hFF);
    endfunction

    initial begin
        #4_000_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int lens [3];
        lens[0] = 1; lens[1] = 5; lens[2] = DEPTH;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        hread(3'd6, 1'b0, rd);
        check("R1", int'(rd), 8'h01);
        check("R1", int'(ovf_flag), 0);
        check("R1", int'(tx_valid), 0);
        check("R1", int'(rx_ready), 0);

        // R2 control bits kept, status bits read-only
        hwrite(3'd6, 8'h5F);
        hread(3'd6, 1'b0, rd);
        check("R2", int'(rd), 8'h5D);

        // R3 R5 standard-with-FIFO sweep
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < lens[k]; i++) hwrite(3'd4, pat(i, k));
            hread(3'd6, 1'b0, rd);
            check("R5", int'(rd[0]), 0);
            check("R5", int'(rd[1]), (lens[k] == DEPTH) ? 1 : 0);
            for (int i = 0; i < lens[k]; i++) tx_take("R3", pat(i, k), 0);
            @(negedge clk);
            check("R3", int'(tx_valid), 0);
        end

        // R6 overflow drop
        for (int i = 0; i < DEPTH; i++) hwrite(3'd4, pat(i, 7));
        check("R6", int'(ovf_flag), 0);
        hwrite(3'd4, 8'hEE);
        check("R6", int'(ovf_flag), 1);
        for (int i = 0; i < DEPTH; i++) tx_take("R6", pat(i, 7), 0);
        @(negedge clk);
        check("R6", int'(tx_valid), 0);
        check("R6", int'(ovf_flag), 1);

        // R9 flush on standard mode
        for (int i = 0; i < 3; i++) hwrite(3'd4, pat(i, 9));
        hwrite(3'd6, 8'h00);
        hread(3'd6, 1'b0, rd);
        check("R9", int'(rd), 8'h01);
        check("R9", int'(ovf_flag), 0);

        // R11 inactive modes ignore FIFO ports
        hwrite(3'd4, 8'h11);
        hwrite(3'd0, 8'h22);
        hwrite(3'd6, 8'h80);
        hwrite(3'd4, 8'h33);
        hwrite(3'd0, 8'h44);
        hread(3'd6, 1'b0, rd);
        check("R11", int'(rd), 8'h81);

        // R4 ECP forward, tagged interleave
        hwrite(3'd6, 8'h60);
        for (int i = 0; i < 10; i++) hwrite((i % 3 == 1) ? 3'd0 : 3'd4, pat(i, 4));
        for (int i = 0; i < 10; i++) tx_take("R4", pat(i, 4), (i % 3 == 1) ? 1 : 0);

        // R7 test mode fill and drain
        hwrite(3'd6, 8'hC0);
        for (int i = 0; i < 6; i++) hwrite(3'd4, pat(i, 6));
        @(negedge clk);
        check("R7", int'(tx_valid), 0);
        for (int i = 0; i < 6; i++) begin
            hread(3'd4, 1'b1, rd);
            check("R7", int'(rd), pat(i, 6));
        end
        hread(3'd6, 1'b0, rd);
        check("R7", int'(rd[0]), 1);

        // R8 configuration registers
        hwrite(3'd6, 8'hE0);
        hread(3'd4, 1'b0, rd);
        check("R8", int'(rd), (1 << 7) | (1 << 4) | (1 << 2));
        hread(3'd5, 1'b0, rd);
        check("R8", int'(rd), (1 << 3) | 3);
        hwrite(3'd4, 8'h55);
        hwrite(3'd0, 8'h66);
        hwrite(3'd6, 8'hC0);
        hread(3'd6, 1'b0, rd);
        check("R8", int'(rd[0]), 1);

        // R10 ECP reverse
        hwrite(3'd6, 8'h60);
        @(negedge clk);
        link_reverse = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            check("R10", int'(rx_ready), 1);
            rx_byte = pat(i, 10); rx_valid = 1'b1;
            @(negedge clk);
            rx_valid = 1'b0;
        end
        @(negedge clk);
        check("R10", int'(rx_ready), 0);
        check("R10", int'(tx_valid), 0);
        for (int i = 0; i < DEPTH; i++) begin
            hread(3'd4, 1'b1, rd);
            check("R10", int'(rd), pat(i, 10));
        end
        hread(3'd6, 1'b0, rd);
        check("R10", int'(rd[0]), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule